// File: doc/BRIEF.md
# Debug Single-Step Execution Controller

This controller sits beside a simple in-order instruction pipeline and decides, cycle by cycle, whether the core may issue its next instruction. It has three modes. In pipelined mode up to `DEPTH` instructions overlap. In serial mode one instruction completes before the next starts, with a fixed stall after each retirement. In step mode the core halts after every instruction and resumes only on a command from the debug port.

The controller also turns breakpoint hit strobes from external comparators into a one-cycle trigger report. The report gives a kind code and a precise/imprecise flag, and it parks the controller in the halted state. Hits on the program counter are caught before the matching instruction issues. Address and data hits are flagged precise only in serial mode. A gate on pending interrupts lets a debugger keep interrupts out while it steps.

The three control bits are latched only at instruction boundaries, which are cycles with nothing in flight.

Top module: `stepDebugCtl`

## Requirements
- R1: Reset leaves all modes off, halted low, no trigger report, and issuePermit high.
- R2: In pipelined mode, issuePermit stays high while fewer than DEPTH instructions are in flight, so a core requesting every cycle issues every cycle with instructions overlapping.
- R3: In serial mode, no instruction is accepted while another is in flight.
- R4: In serial mode, an issue is never accepted within STALL_CYC clock edges of a retirement. The next issue comes at the earliest STALL_CYC+1 edges after the retire edge.
- R5: In step mode, one instruction issues and halted rises in the cycle after that instruction retires. Each resume strobe while halted releases exactly one more instruction.
- R6: A resume strobe while not halted has no effect.
- R7: If step mode is cleared while halted, the next resume returns the controller to free-running issue without further halts.
- R8: irqAccept is high when irqPend is high, nothing is in flight and the controller is not halted. It is held low while both step mode and ignore-interrupts are set, and it is held low while halted.
- R9: A PC hit while the core requests issue drops issuePermit in the same cycle, so that instruction does not issue. In the next cycle trigValid pulses with trigKind 1 and trigPrecise 1, and halted rises.
- R10: An address hit or data hit gives, one cycle later, a trigValid pulse with trigKind 2 (address) or 3 (data), and halted rises. Address wins when both arrive together. trigPrecise is 0 in pipelined mode.
- R11: In serial mode, address and data reports carry trigPrecise 1, and no instruction issues between the hit and the following resume.
- R12: A resume while halted by a trigger clears halted, and issue restarts.
- R13: Changes to the control bits while instructions are in flight do not take effect until the pipeline has drained.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ssmEn | input | 1 | Step mode request |
| nplEn | input | 1 | Serial (non-overlapped) mode request |
| ipiEn | input | 1 | Ignore pending interrupts while stepping |
| resumeStb | input | 1 | Resume command strobe from the debug port |
| issueReq | input | 1 | Core has an instruction ready to issue |
| retireStb | input | 1 | Core retired its oldest instruction this cycle |
| irqPend | input | 1 | Interrupt request pending |
| pcHit | input | 1 | PC breakpoint match on the instruction requesting issue |
| addrHit | input | 1 | Address breakpoint match from an in-flight instruction |
| dataHit | input | 1 | Data breakpoint match from an in-flight instruction |
| issuePermit | output | 1 | Core may issue this cycle |
| halted | output | 1 | Controller is halted awaiting resume |
| irqAccept | output | 1 | Pending interrupt may be taken this cycle |
| trigValid | output | 1 | One-cycle breakpoint report |
| trigKind | output | 2 | Report kind: 1 PC, 2 address, 3 data |
| trigPrecise | output | 1 | Report is precise |

## Verification
The core is stood in for by a fixed-latency stub that retires each instruction three cycles after issue. Issue is driven in three ways. A continuous request shows overlapping issue in pipelined mode. A random on/off request in serial mode tests non-overlap and the stall gap, which are the cases where a wrong gate issues too early. Resume strobes are sent both while halted and while an instruction is still in flight, which separates a correct single-step handshake from one that releases two instructions. Random address and data hits in both modes, plus coincident hits, check the kind priority and the precise flag against the mode that was latched at the last boundary.

// File: rtl/stepDebugPkg.sv
package stepDebugPkg;

  typedef enum logic [1:0] {
    ST_RUN  = 2'd0,
    ST_STEP = 2'd1,
    ST_HALT = 2'd2
  } stepState_e;

  typedef enum logic [1:0] {
    TK_NONE = 2'd0,
    TK_PC   = 2'd1,
    TK_ADDR = 2'd2,
    TK_DATA = 2'd3
  } trigKind_e;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic issueFire;
    logic trigCapture;
    logic trigPc;
  } ctlStrobe_t;

  // state the datapath hands back to the sequencer
  typedef struct packed {
    logic boundary;
    logic slotFree;
    logic stallDone;
    logic ssmMode;
    logic nplMode;
    logic ipiMode;
  } dpStatus_t;

endpackage

// File: rtl/stepDebugPath.sv
module stepDebugPath
  import stepDebugPkg::*;
#(
  parameter int DEPTH = 4,
  parameter int STALL = 5
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       ssmEn,
  input  logic       nplEn,
  input  logic       ipiEn,
  input  logic       retireStb,
  input  logic       addrHit,
  input  logic       dataHit,
  input  ctlStrobe_t ctl,
  output dpStatus_t  status,
  output logic       trigValid,
  output logic [1:0] trigKind,
  output logic       trigPrecise
);

  localparam int CW = $clog2(DEPTH + 1);

  logic [CW-1:0] inflight;
  logic          ssmQ, nplQ, ipiQ;
  logic          stallDone;
  trigKind_e     kindQ;
  logic          idle;

  assign idle = (inflight == '0);

  // in-flight count and mode latch (modes move only at a boundary)
  always_ff @(posedge clk) begin
    if (!rstN) begin
      inflight <= '0;
      ssmQ     <= 1'b0;
      nplQ     <= 1'b0;
      ipiQ     <= 1'b0;
    end else begin
      case ({ctl.issueFire, retireStb})
        2'b10:   inflight <= inflight + CW'(1);
        2'b01:   inflight <= inflight - CW'(1);
        default: inflight <= inflight;
      endcase
      if (idle) begin
        ssmQ <= ssmEn;
        nplQ <= nplEn;
        ipiQ <= ipiEn;
      end
    end
  end

  // serial-mode stall after each retirement
  generate
    if (STALL > 0) begin : g_stall
      localparam int SW = $clog2(STALL + 2);
      logic [SW-1:0] stallCnt;
      always_ff @(posedge clk) begin
        if (!rstN) begin
          stallCnt <= '0;
        end else if (retireStb && nplQ) begin
          stallCnt <= SW'(STALL);
        end else if (stallCnt != '0) begin
          stallCnt <= stallCnt - SW'(1);
        end
      end
      assign stallDone = (stallCnt == '0);
    end else begin : g_noStall
      assign stallDone = 1'b1;
    end
  endgenerate

  // trigger report register
  always_ff @(posedge clk) begin
    if (!rstN) begin
      trigValid   <= 1'b0;
      kindQ       <= TK_NONE;
      trigPrecise <= 1'b0;
    end else begin
      trigValid <= ctl.trigCapture;
      if (ctl.trigCapture) begin
        if (ctl.trigPc)   kindQ <= TK_PC;
        else if (addrHit) kindQ <= TK_ADDR;
        else if (dataHit) kindQ <= TK_DATA;
        else              kindQ <= TK_NONE;
        trigPrecise <= ctl.trigPc || nplQ;
      end
    end
  end

  assign trigKind = kindQ;

  always_comb begin
    status.boundary  = idle;
    status.slotFree  = (inflight < CW'(DEPTH));
    status.stallDone = stallDone;
    status.ssmMode   = ssmQ;
    status.nplMode   = nplQ;
    status.ipiMode   = ipiQ;
  end

endmodule

// File: rtl/stepDebugFsm.sv
module stepDebugFsm
  import stepDebugPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       resumeStb,
  input  logic       issueReq,
  input  logic       retireStb,
  input  logic       irqPend,
  input  logic       pcHit,
  input  logic       addrHit,
  input  logic       dataHit,
  input  dpStatus_t  status,
  output ctlStrobe_t ctl,
  output logic       issuePermit,
  output logic       halted,
  output logic       irqAccept
);

  stepState_e state, stateNext;
  logic serial, permitBase, pcTrig, anyTrig, fire;

  always_comb begin
    serial      = status.nplMode || status.ssmMode;
    permitBase  = (state == ST_RUN) && status.stallDone && status.slotFree &&
                  (!serial || status.boundary);
    pcTrig      = pcHit && issueReq && permitBase;
    issuePermit = permitBase && !pcHit;
    fire        = issuePermit && issueReq;
    anyTrig     = pcTrig || addrHit || dataHit;
    ctl         = '{issueFire: fire, trigCapture: anyTrig, trigPc: pcTrig};

    stateNext = state;
    if (anyTrig) begin
      stateNext = ST_HALT;
    end else begin
      unique case (state)
        ST_RUN:  if (status.ssmMode && fire) stateNext = ST_STEP;
        ST_STEP: if (retireStb)              stateNext = ST_HALT;
        ST_HALT: if (resumeStb)              stateNext = ST_RUN;
        default:                             stateNext = ST_RUN;
      endcase
    end

    halted    = (state == ST_HALT);
    irqAccept = irqPend && status.boundary && !halted &&
                !(status.ssmMode && status.ipiMode);
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_RUN;
    else       state <= stateNext;
  end

endmodule

// File: rtl/stepDebugCtl.sv
module stepDebugCtl
  import stepDebugPkg::*;
#(
  parameter int DEPTH     = 4,
  parameter int STALL_CYC = 5
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       ssmEn,
  input  logic       nplEn,
  input  logic       ipiEn,
  input  logic       resumeStb,
  input  logic       issueReq,
  input  logic       retireStb,
  input  logic       irqPend,
  input  logic       pcHit,
  input  logic       addrHit,
  input  logic       dataHit,
  output logic       issuePermit,
  output logic       halted,
  output logic       irqAccept,
  output logic       trigValid,
  output logic [1:0] trigKind,
  output logic       trigPrecise
);

  ctlStrobe_t ctl;
  dpStatus_t  status;

  stepDebugFsm u_fsm (
    .clk        (clk),
    .rstN       (rstN),
    .resumeStb  (resumeStb),
    .issueReq   (issueReq),
    .retireStb  (retireStb),
    .irqPend    (irqPend),
    .pcHit      (pcHit),
    .addrHit    (addrHit),
    .dataHit    (dataHit),
    .status     (status),
    .ctl        (ctl),
    .issuePermit(issuePermit),
    .halted     (halted),
    .irqAccept  (irqAccept)
  );

  stepDebugPath #(
    .DEPTH(DEPTH),
    .STALL(STALL_CYC)
  ) u_path (
    .clk        (clk),
    .rstN       (rstN),
    .ssmEn      (ssmEn),
    .nplEn      (nplEn),
    .ipiEn      (ipiEn),
    .retireStb  (retireStb),
    .addrHit    (addrHit),
    .dataHit    (dataHit),
    .ctl        (ctl),
    .status     (status),
    .trigValid  (trigValid),
    .trigKind   (trigKind),
    .trigPrecise(trigPrecise)
  );

endmodule

// File: rtl/stepDebugChecker.sv
module stepDebugChecker #(
  parameter int STALL = 5
) (
  input logic       clk,
  input logic       rstN,
  input logic       issueReq,
  input logic       issuePermit,
  input logic       halted,
  input logic       irqAccept,
  input logic       resumeStb,
  input logic       retireStb,
  input logic       pcHit,
  input logic       addrHit,
  input logic       dataHit,
  input logic       trigValid,
  input logic [1:0] trigKind,
  input logic       trigPrecise,
  input logic       ssmMode,
  input logic       nplMode,
  input logic       ipiMode,
  input logic       idle
);

  localparam int W = $clog2(STALL + 2);
  logic [W-1:0] sinceRetire;

  always_ff @(posedge clk) begin
    if (!rstN)                      sinceRetire <= W'(STALL);
    else if (retireStb && nplMode)  sinceRetire <= '0;
    else if (sinceRetire < W'(STALL)) sinceRetire <= sinceRetire + W'(1);
  end

  assert_serial_R3: assert property (@(posedge clk) disable iff (!rstN)
    (nplMode && !idle) |-> !issuePermit);

  assert_stall_R4: assert property (@(posedge clk) disable iff (!rstN)
    (issuePermit && issueReq && nplMode) |-> (sinceRetire >= W'(STALL)));

  assert_halt_blocks_R5: assert property (@(posedge clk) disable iff (!rstN)
    halted |-> !issuePermit);

  assert_ipi_gate_R8: assert property (@(posedge clk) disable iff (!rstN)
    (ssmMode && ipiMode) |-> !irqAccept);

  assert_pc_report_R9: assert property (@(posedge clk) disable iff (!rstN)
    (trigValid && trigKind == 2'd1) |-> (trigPrecise && $past(pcHit && issueReq)));

  assert_hit_report_R10: assert property (@(posedge clk) disable iff (!rstN)
    (addrHit || dataHit) |=> (trigValid && halted && trigKind != 2'd1));

  assert_resume_only_R12: assert property (@(posedge clk) disable iff (!rstN)
    $fell(halted) |-> $past(resumeStb));

endmodule

bind stepDebugCtl stepDebugChecker #(.STALL(STALL_CYC)) u_check (
  .clk        (clk),
  .rstN       (rstN),
  .issueReq   (issueReq),
  .issuePermit(issuePermit),
  .halted     (halted),
  .irqAccept  (irqAccept),
  .resumeStb  (resumeStb),
  .retireStb  (retireStb),
  .pcHit      (pcHit),
  .addrHit    (addrHit),
  .dataHit    (dataHit),
  .trigValid  (trigValid),
  .trigKind   (trigKind),
  .trigPrecise(trigPrecise),
  .ssmMode    (status.ssmMode),
  .nplMode    (status.nplMode),
  .ipiMode    (status.ipiMode),
  .idle       (status.boundary)
);

// File: tb/stepDebugCtl_bench.sv
module stepDebugCtl_bench;

  localparam int DEPTH = 4;
  localparam int STALL = 5;
  localparam int LAT   = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic ssmEn = 0, nplEn = 0, ipiEn = 0, resumeStb = 0, issueReq = 0;
  logic irqPend = 0, pcHit = 0, addrHit = 0, dataHit = 0;
  logic issuePermit, halted, irqAccept, trigValid, trigPrecise;
  logic [1:0] trigKind;
  logic [LAT-1:0] retPipe;
  logic retireStb;
  logic fire;

  int checks = 0, fails = 0;
  int edgeCnt = 0, issued = 0, retired = 0, lastRetire = -1000;
  int viol3 = 0, viol4 = 0, maxInflight = 0;
  bit monNpl = 0;
  int base;

  always #10 clk = ~clk;

  assign retireStb = retPipe[LAT-1];

  stepDebugCtl #(.DEPTH(DEPTH), .STALL_CYC(STALL)) u_stepDebugCtl (
    .clk(clk), .rstN(rstN), .ssmEn(ssmEn), .nplEn(nplEn), .ipiEn(ipiEn),
    .resumeStb(resumeStb), .issueReq(issueReq), .retireStb(retireStb),
    .irqPend(irqPend), .pcHit(pcHit), .addrHit(addrHit), .dataHit(dataHit),
    .issuePermit(issuePermit), .halted(halted), .irqAccept(irqAccept),
    .trigValid(trigValid), .trigKind(trigKind), .trigPrecise(trigPrecise)
  );

  // core stub: fixed-latency in-order pipeline plus monitors
  always @(posedge clk) begin
    if (!rstN) begin
      retPipe <= '0;
    end else begin
      fire = issueReq && issuePermit;
      retPipe <= {retPipe[LAT-2:0], fire};
      if (fire) begin
        if (monNpl) begin
          if (issued - retired != 0) viol3++;
          if (edgeCnt - lastRetire <= STALL) viol4++;
        end
        issued++;
      end
      if (retireStb) begin
        retired++;
        lastRetire = edgeCnt;
      end
      if (issued - retired > maxInflight) maxInflight = issued - retired;
      edgeCnt++;
    end
  end

  function automatic int expKind(bit p, bit a, bit d);
    return p ? 1 : a ? 2 : d ? 3 : 0;
  endfunction

  function automatic int expPrecise(bit p, bit npl);
    return (p || npl) ? 1 : 0;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulseResume;
    resumeStb = 1'b1;
    cyc(1);
    resumeStb = 1'b0;
  endtask

  task automatic drainAndSet(input bit npl);
    issueReq = 0;
    cyc(8);
    nplEn = npl;
    cyc(2);
    pulseResume();
    issueReq = 1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run hung, actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    cyc(3);
    rstN = 1;
    cyc(1);

    // R1 reset state
    chk("R1 halted", halted, 0);
    chk("R1 trigValid", trigValid, 0);
    chk("R1 issuePermit", issuePermit, 1);
    chk("R1 irqAccept", irqAccept, 0);

    // R8 free-running accept at a boundary
    irqPend = 1; #1;
    chk("R8 free irqAccept", irqAccept, 1);
    irqPend = 0;

    // R2 pipelined overlap
    base = issued;
    issueReq = 1;
    cyc(8);
    issueReq = 0;
    chk("R2 issue every cycle", issued - base, 8);
    chk("R2 overlap depth", maxInflight, LAT);
    cyc(6);

    // R6 resume while running
    pulseResume();
    chk("R6 free resume ignored", halted, 0);

    // R5 step mode, R6 resume while stepping
    ssmEn = 1;
    cyc(2);
    base = issued;
    issueReq = 1;
    cyc(1);
    pulseResume();
    for (int i = 0; i < 10 && !retireStb; i++) cyc(1);
    chk("R5 not halted at retire", halted, 0);
    cyc(1);
    chk("R5 halted after retire", halted, 1);
    cyc(4);
    chk("R6 one issue despite resume in flight", issued - base, 1);
    for (int k = 0; k < 3; k++) begin
      base = issued;
      pulseResume();
      cyc(7);
      chk("R5 halted again", halted, 1);
      chk("R5 one issue per resume", issued - base, 1);
    end

    // R8 stepping with interrupts allowed, then ignored
    irqPend = 1; #1;
    chk("R8 no accept while halted", irqAccept, 0);
    pulseResume();
    chk("R8 step accept", irqAccept, 1);
    cyc(7);
    ipiEn = 1;
    cyc(2);
    pulseResume();
    chk("R8 step ignore", irqAccept, 0);
    irqPend = 0;
    cyc(7);
    ipiEn = 0;

    // R7 leave step mode while halted
    ssmEn = 0;
    cyc(2);
    base = issued;
    pulseResume();
    cyc(10);
    chk("R7 free-running", halted, 0);
    chk("R7 issue count", issued - base, 10);

    // R9 PC hit
    pcHit = 1; #1;
    chk("R9 permit dropped", issuePermit, 0);
    base = issued;
    cyc(1);
    pcHit = 0;
    chk("R9 not issued", issued - base, 0);
    chk("R9 trigValid", trigValid, 1);
    chk("R9 kind", trigKind, expKind(1, 0, 0));
    chk("R9 precise", trigPrecise, expPrecise(1, 0));
    chk("R9 halted", halted, 1);
    cyc(1);
    chk("R9 pulse", trigValid, 0);
    cyc(5);
    chk("R9 held", issued - base, 0);

    // R12 resume after trigger
    pulseResume();
    base = issued;
    cyc(4);
    chk("R12 halted cleared", halted, 0);
    chk("R12 issue restarts", issued - base, 4);

    // R10 address, coincident, data
    addrHit = 1; cyc(1); addrHit = 0;
    chk("R10 addr valid", trigValid, 1);
    chk("R10 addr kind", trigKind, expKind(0, 1, 0));
    chk("R10 addr imprecise", trigPrecise, expPrecise(0, 0));
    chk("R10 halted", halted, 1);
    cyc(5); pulseResume(); cyc(2);
    addrHit = 1; dataHit = 1; cyc(1); addrHit = 0; dataHit = 0;
    chk("R10 priority kind", trigKind, expKind(0, 1, 1));
    cyc(5); pulseResume(); cyc(2);
    dataHit = 1; cyc(1); dataHit = 0;
    chk("R10 data kind", trigKind, expKind(0, 0, 1));
    chk("R10 data imprecise", trigPrecise, 0);

    // R13 mode change while in flight
    cyc(5); pulseResume(); cyc(2);
    nplEn = 1; addrHit = 1; cyc(1); addrHit = 0;
    chk("R13 mode not yet taken", trigPrecise, 0);
    issueReq = 0;
    cyc(8);

    // R11 serial mode precise report
    issueReq = 1;
    pulseResume();
    cyc(1);
    dataHit = 1;
    base = issued;
    cyc(1);
    dataHit = 0;
    chk("R11 valid", trigValid, 1);
    chk("R11 kind", trigKind, 3);
    chk("R11 precise", trigPrecise, expPrecise(0, 1));
    chk("R11 halted", halted, 1);
    cyc(8);
    chk("R11 no issue before resume", issued - base, 0);

    // R3 / R4 random serial traffic
    pulseResume();
    monNpl = 1;
    base = issued;
    for (int i = 0; i < 400; i++) begin
      issueReq = ($urandom_range(0, 3) != 0);
      cyc(1);
    end
    monNpl = 0;
    chk("R3 overlap violations", viol3, 0);
    chk("R4 stall violations", viol4, 0);
    chk("R4 serial progress", (issued - base > 10) ? 1 : 0, 1);

    // R10 / R11 random hits in both modes
    for (int m = 0; m < 2; m++) begin
      drainAndSet(m[0]);
      for (int i = 0; i < 150; i++) begin
        bit a, d;
        int r;
        r = int'($urandom_range(0, 15));
        a = (r == 0);
        d = (r == 1 || r == 2);
        resumeStb = halted && ($urandom_range(0, 1) == 1);
        addrHit = a;
        dataHit = d;
        cyc(1);
        resumeStb = 0;
        addrHit = 0;
        dataHit = 0;
        if (a || d) begin
          chk(m ? "R11 random valid" : "R10 random valid", trigValid, 1);
          chk(m ? "R11 random kind" : "R10 random kind", trigKind, expKind(0, a, d));
          chk(m ? "R11 random precise" : "R10 random precise", trigPrecise,
              expPrecise(0, m[0]));
        end
      end
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule